// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block compares two IEEE 754 binary operands of half, single or double precision and reports the result as a four-bit N/Z/C/V condition code. The outcome is always exactly one of less-than, equal, greater-than or unordered. One select forces the second operand to positive zero. A second select chooses between quiet handling, where only signaling NaNs are invalid, and signaling handling, where any NaN is invalid.

An invalid operation either sets a sticky status flag or raises a one-cycle synchronous trap request, depending on a trap-enable input. A format code that is undefined, or half precision in a build without half support, raises an error output for one cycle. In that case the flags are left as they were and no exception is raised. The flags register on the clock edge where `valid_i` is high and hold otherwise.

Top module: `fp_cmp_flags`

## Requirements
- R1: Each accepted compare yields exactly one of less-than, equal, greater-than or unordered.
- R2: Flag encodings on `nzcv_o` (bit 3 = N, bit 0 = V) are: first operand less gives 4'b1000, equal gives 4'b0110 and greater gives 4'b0010.
- R3: If either operand is a NaN (exponent all ones, fraction non-zero), the result is unordered and `nzcv_o` becomes 4'b0011.
- R4: Positive zero and negative zero compare equal.
- R5: Non-NaN operands are ordered by sign first, then by the exponent and fraction bits taken as an unsigned magnitude. The magnitude order is reversed when both operands are negative, and subnormals are compared exactly with no flushing.
- R6: With `cmp_zero_i` high, `op_b_i` is ignored and the first operand is compared against positive zero.
- R7: With `sig_mode_i` low, an invalid operation is raised only when at least one operand is a signaling NaN, which is a NaN whose top fraction bit is 0.
- R8: With `sig_mode_i` high, an invalid operation is raised for any NaN operand, quiet or signaling.
- R9: If `trap_en_i` is 1, an invalid operation pulses `trap_o` for one cycle and leaves `inv_sticky_o` unchanged. If `trap_en_i` is 0, it sets `inv_sticky_o`, which then stays 1 until reset.
- R10: `fmt_i` 2'b00 selects single precision (operand bits 31:0), 2'b01 selects double (63:0) and 2'b11 selects half (15:0), the last only when `HALF_EN` is 1. Operand bits above the selected width are ignored.
- R11: `fmt_i` 2'b10, or 2'b11 when `HALF_EN` is 0, pulses `fmt_err_o` and leaves `nzcv_o`, `trap_o` and `inv_sticky_o` unaffected.
- R12: Results appear one clock after the edge that samples `valid_i` high. While `valid_i` is low, `nzcv_o` holds and `trap_o` and `fmt_err_o` are 0.
- R13: After reset, `nzcv_o` is 4'b0000 and `inv_sticky_o`, `trap_o` and `fmt_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Compare request this cycle |
| fmt_i | input | 2 | Operand format code |
| cmp_zero_i | input | 1 | Compare first operand against +0 |
| sig_mode_i | input | 1 | Any NaN is invalid when high |
| trap_en_i | input | 1 | Invalid raises trap instead of sticky flag |
| op_a_i | input | 64 | First operand, right-aligned |
| op_b_i | input | 64 | Second operand, right-aligned |
| nzcv_o | output | 4 | Condition flags N, Z, C, V |
| inv_sticky_o | output | 1 | Sticky invalid-operation status |
| trap_o | output | 1 | Synchronous trap request pulse |
| fmt_err_o | output | 1 | Undefined format pulse |

## Verification
Every result (`nzcv_o`, `trap_o`, `fmt_err_o` and any change of `inv_sticky_o`) is due exactly one rising edge after the request is sampled. The bench drives each request on a falling edge, lets one rising edge pass and samples on the following falling edge, so each check sees the register output of that request alone. Hold behaviour under idle cycles and undefined formats is checked in the cycle after the stimulus, against the value recorded before it.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  localparam int OPW   = 64;
  localparam int MAGW  = OPW - 1;
  localparam int FLAGW = 4;

  typedef enum logic [1:0] {
    FMT_S   = 2'b00,
    FMT_D   = 2'b01,
    FMT_RSV = 2'b10,
    FMT_H   = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    ORD_LT = 2'd0,
    ORD_EQ = 2'd1,
    ORD_GT = 2'd2,
    ORD_UN = 2'd3
  } ord_e;

  typedef struct packed {
    logic            sign;
    logic [MAGW-1:0] mag;
    logic            is_nan;
    logic            is_snan;
    logic            is_zero;
  } opnd_t;

  // Split a right-aligned operand into sign, magnitude and NaN/zero class.
  function automatic opnd_t unpack_op(fmt_e f, logic [OPW-1:0] r);
    opnd_t o;
    logic  exp_ones;
    logic  frac_nz;
    logic  quiet_bit;
    o         = '0;
    exp_ones  = 1'b0;
    frac_nz   = 1'b0;
    quiet_bit = 1'b0;
    case (f)
      FMT_H: begin
        o.sign    = r[15];
        o.mag     = {48'd0, r[14:0]};
        exp_ones  = &r[14:10];
        frac_nz   = |r[9:0];
        quiet_bit = r[9];
      end
      FMT_S: begin
        o.sign    = r[31];
        o.mag     = {32'd0, r[30:0]};
        exp_ones  = &r[30:23];
        frac_nz   = |r[22:0];
        quiet_bit = r[22];
      end
      FMT_D: begin
        o.sign    = r[63];
        o.mag     = r[62:0];
        exp_ones  = &r[62:52];
        frac_nz   = |r[51:0];
        quiet_bit = r[51];
      end
      default: o = '0;
    endcase
    o.is_nan  = exp_ones & frac_nz;
    o.is_snan = o.is_nan & ~quiet_bit;
    o.is_zero = (o.mag == '0);
    return o;
  endfunction

  // Sign-magnitude "a below b" for non-NaN, not-both-zero operands.
  function automatic logic a_below_b(opnd_t a, opnd_t b);
    logic r;
    if (a.sign != b.sign) r = a.sign;
    else if (!a.sign)     r = (a.mag < b.mag);
    else                  r = (a.mag > b.mag);
    return r;
  endfunction

  function automatic logic [FLAGW-1:0] flags_of(ord_e o);
    logic [FLAGW-1:0] n;
    case (o)
      ORD_LT:  n = 4'b1000;
      ORD_EQ:  n = 4'b0110;
      ORD_GT:  n = 4'b0010;
      default: n = 4'b0011;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/fpcmp_unpack.sv
module fpcmp_unpack
  import fpcmp_pkg::*;
(
  input  fmt_e           fmt_i,
  input  logic [OPW-1:0] raw_i,
  output opnd_t          op_o
);

  always_comb op_o = unpack_op(fmt_i, raw_i);

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
(
  input  opnd_t a_i,
  input  opnd_t b_i,
  output logic  lt_o,
  output logic  eq_o,
  output logic  gt_o,
  output logic  un_o,
  output ord_e  ord_o
);

  logic both_zero;
  logic same_bits;
  logic below;

  always_comb begin
    un_o      = a_i.is_nan | b_i.is_nan;
    both_zero = a_i.is_zero & b_i.is_zero;
    same_bits = (a_i.sign == b_i.sign) && (a_i.mag == b_i.mag);
    below     = a_below_b(a_i, b_i);
    eq_o      = ~un_o & (both_zero | same_bits);
    lt_o      = ~un_o & ~eq_o & below;
    gt_o      = ~un_o & ~eq_o & ~below;
  end

  always_comb begin
    if (un_o)      ord_o = ORD_UN;
    else if (eq_o) ord_o = ORD_EQ;
    else if (lt_o) ord_o = ORD_LT;
    else           ord_o = ORD_GT;
  end

endmodule

// File: rtl/fpcmp_flagreg.sv
module fpcmp_flagreg
  import fpcmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             fmt_bad_i,
  input  ord_e             ord_i,
  input  logic             inv_i,
  input  logic             trap_en_i,
  output logic [FLAGW-1:0] nzcv_o,
  output logic             sticky_o,
  output logic             trap_o,
  output logic             err_o
);

  logic take;
  logic raise_trap;
  logic raise_flag;

  always_comb begin
    take       = valid_i & ~fmt_bad_i;
    raise_trap = take & inv_i & trap_en_i;
    raise_flag = take & inv_i & ~trap_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nzcv_o   <= '0;
      sticky_o <= 1'b0;
      trap_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      trap_o <= raise_trap;
      err_o  <= valid_i & fmt_bad_i;
      if (take)       nzcv_o   <= flags_of(ord_i);
      if (raise_flag) sticky_o <= 1'b1;
    end
  end

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && fmt_bad_i) |=> ($stable(nzcv_o) && err_o && !trap_o && $stable(sticky_o)));

  // R9
  trap_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && inv_i && trap_en_i) |=> (trap_o && $stable(sticky_o)));

  // R9
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(sticky_o));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(nzcv_o) && !trap_o && !err_o));

  // R3
  unord_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ord_i == ORD_UN) |=> (nzcv_o == 4'b0011));

endmodule

// File: rtl/fp_cmp_flags.sv
module fp_cmp_flags
  import fpcmp_pkg::*;
#(
  parameter bit HALF_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_i,
  input  logic [1:0]  fmt_i,
  input  logic        cmp_zero_i,
  input  logic        sig_mode_i,
  input  logic        trap_en_i,
  input  logic [63:0] op_a_i,
  input  logic [63:0] op_b_i,
  output logic [3:0]  nzcv_o,
  output logic        inv_sticky_o,
  output logic        trap_o,
  output logic        fmt_err_o
);

  localparam int NOPS = 2;

  fmt_e           fmt;
  logic           fmt_bad;
  logic [OPW-1:0] raw   [NOPS];
  opnd_t          opnd  [NOPS];
  logic           lt, eq, gt, un;
  ord_e           ord;
  logic           any_nan;
  logic           any_snan;
  logic           inv;

  always_comb begin
    fmt     = fmt_e'(fmt_i);
    fmt_bad = (fmt == FMT_RSV) || ((fmt == FMT_H) && !HALF_EN);
    raw[0]  = op_a_i;
    raw[1]  = cmp_zero_i ? '0 : op_b_i;
  end

  for (genvar g = 0; g < NOPS; g++) begin : g_unpack
    fpcmp_unpack u_unpack (
      .fmt_i (fmt),
      .raw_i (raw[g]),
      .op_o  (opnd[g])
    );
  end

  fpcmp_order u_order (
    .a_i   (opnd[0]),
    .b_i   (opnd[1]),
    .lt_o  (lt),
    .eq_o  (eq),
    .gt_o  (gt),
    .un_o  (un),
    .ord_o (ord)
  );

  always_comb begin
    any_nan  = opnd[0].is_nan  | opnd[1].is_nan;
    any_snan = opnd[0].is_snan | opnd[1].is_snan;
    inv      = any_snan | (sig_mode_i & any_nan);
  end

  fpcmp_flagreg u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .fmt_bad_i (fmt_bad),
    .ord_i     (ord),
    .inv_i     (inv),
    .trap_en_i (trap_en_i),
    .nzcv_o    (nzcv_o),
    .sticky_o  (inv_sticky_o),
    .trap_o    (trap_o),
    .err_o     (fmt_err_o)
  );

  // R1
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({lt, eq, gt, un}));

  // R3
  nan_unord_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opnd[0].is_nan || opnd[1].is_nan) |-> (ord == ORD_UN));

  // R4
  zero_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opnd[0].is_zero && opnd[1].is_zero && !fmt_bad) |-> eq);

  // R6
  cmpz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_zero_i |-> (opnd[1].is_zero && !opnd[1].sign && !opnd[1].is_nan));

  // R7
  quiet_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sig_mode_i && !opnd[0].is_snan && !opnd[1].is_snan) |-> !inv);

endmodule

// File: tb/sim_fp_cmp_flags.sv
module sim_fp_cmp_flags;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic        cmpz = 1'b0;
  logic        sig = 1'b0;
  logic        ten = 1'b0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic [3:0]  nzcv0, nzcv1;
  logic        stk0, stk1, trp0, trp1, err0, err1;

  int checks = 0;
  int fails  = 0;
  logic [3:0] exp_nzcv = '0;
  logic       exp_stk  = 1'b0;

  always #2.5 clk = ~clk;

  fp_cmp_flags #(.HALF_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid), .fmt_i(fmt), .cmp_zero_i(cmpz),
    .sig_mode_i(sig), .trap_en_i(ten), .op_a_i(a), .op_b_i(b),
    .nzcv_o(nzcv0), .inv_sticky_o(stk0), .trap_o(trp0), .fmt_err_o(err0));

  fp_cmp_flags #(.HALF_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid), .fmt_i(fmt), .cmp_zero_i(cmpz),
    .sig_mode_i(sig), .trap_en_i(ten), .op_a_i(a), .op_b_i(b),
    .nzcv_o(nzcv1), .inv_sticky_o(stk1), .trap_o(trp1), .fmt_err_o(err1));

  function automatic logic [63:0] lowmask(int w);
    return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic int ebits(logic [1:0] f);
    return (f == 2'b11) ? 5 : (f == 2'b00) ? 8 : 11;
  endfunction

  function automatic int fbits(logic [1:0] f);
    return (f == 2'b11) ? 10 : (f == 2'b00) ? 23 : 52;
  endfunction

  function automatic logic m_nan(logic [1:0] f, logic [63:0] x);
    logic [63:0] e, fr;
    e  = (x >> fbits(f)) & lowmask(ebits(f));
    fr = x & lowmask(fbits(f));
    return (e == lowmask(ebits(f))) && (fr != 0);
  endfunction

  function automatic logic m_snan(logic [1:0] f, logic [63:0] x);
    return m_nan(f, x) && (((x >> (fbits(f) - 1)) & 64'd1) == 0);
  endfunction

  function automatic longint m_key(logic [1:0] f, logic [63:0] x);
    int w;
    longint m;
    w = 1 + ebits(f) + fbits(f);
    m = longint'(x & lowmask(w - 1));
    return (((x >> (w - 1)) & 64'd1) != 0) ? -m : m;
  endfunction

  function automatic logic [63:0] gen(logic [1:0] f, int idx);
    int eb, fb, w;
    logic [63:0] ev, fv, v;
    eb = ebits(f); fb = fbits(f); w = 1 + eb + fb;
    case ((idx / 5) % 5)
      0: ev = 0;
      1: ev = 1;
      2: ev = lowmask(eb - 1);
      3: ev = lowmask(eb) - 1;
      default: ev = lowmask(eb);
    endcase
    case (idx % 5)
      0: fv = 0;
      1: fv = 1;
      2: fv = lowmask(fb - 1);
      3: fv = 64'd1 << (fb - 1);
      default: fv = lowmask(fb);
    endcase
    v = (ev << fb) | fv;
    if (idx >= 25) v = v | (64'd1 << (w - 1));
    return (64'hA5A5_5A5A_C3C3_3C3C & ~lowmask(w)) | v;
  endfunction

  task automatic check(string tag, logic [6:0] got, logic [6:0] expv);
    checks++;
    if (got !== expv) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_cmp(logic [1:0] f, logic [63:0] x, logic [63:0] y,
                        logic cz, logic sg, logic te, string tag);
    logic [63:0] ya, yb;
    logic nan_any, snan_any, inv, bad;
    longint ka, kb;
    logic [3:0] en;
    valid = 1'b1; fmt = f; a = x; b = y; cmpz = cz; sig = sg; ten = te;
    bad = (f == 2'b10);
    ya = x; yb = cz ? 64'd0 : y;
    en = exp_nzcv;
    inv = 1'b0;
    if (!bad) begin
      nan_any  = m_nan(f, ya)  || m_nan(f, yb);
      snan_any = m_snan(f, ya) || m_snan(f, yb);
      inv = snan_any || (sg && nan_any);
      ka = m_key(f, ya); kb = m_key(f, yb);
      if (nan_any)      en = 4'b0011;
      else if (ka == kb) en = 4'b0110;
      else if (ka < kb)  en = 4'b1000;
      else               en = 4'b0010;
      if (inv && !te) exp_stk = 1'b1;
    end
    exp_nzcv = en;
    step();
    check(tag, {nzcv0, trp0, stk0, err0}, {en, inv && te && !bad, exp_stk, bad});
  endtask

  task automatic do_reset();
    valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_nzcv = '0;
    exp_stk  = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] held;
    do_reset();
    // R13 reset state
    check("R13", {nzcv0, trp0, stk0, err0}, 7'b0000000);
    check("R13", {nzcv1, trp1, stk1, err1}, 7'b0000000);

    // R9: trap path keeps sticky clear, flag path sets it and it stays
    do_cmp(2'b00, 64'h7F80_0001, 64'h3F80_0000, 1'b0, 1'b0, 1'b1, "R9 trap");
    do_cmp(2'b00, 64'h7F80_0001, 64'h3F80_0000, 1'b0, 1'b0, 1'b0, "R9 sticky");
    do_cmp(2'b00, 64'h3F80_0000, 64'h4000_0000, 1'b0, 1'b0, 1'b0, "R9 sticky hold");
    // R7: quiet NaN in quiet mode is not invalid
    do_reset();
    do_cmp(2'b00, 64'h7FC0_0000, 64'h0, 1'b0, 1'b0, 1'b1, "R7 qnan");
    // R8: quiet NaN in signaling mode is invalid
    do_cmp(2'b00, 64'h7FC0_0000, 64'h0, 1'b0, 1'b1, 1'b1, "R8 qnan");
    // R4: -0 vs +0 per format
    do_cmp(2'b11, 64'h8000, 64'h0, 1'b0, 1'b0, 1'b0, "R4 half");
    do_cmp(2'b00, 64'h8000_0000, 64'h0, 1'b0, 1'b0, 1'b0, "R4 single");
    do_cmp(2'b01, 64'h8000_0000_0000_0000, 64'h0, 1'b0, 1'b0, 1'b0, "R4 double");
    // R5: subnormals exact, negatives reversed
    do_cmp(2'b00, 64'h0000_0001, 64'h0000_0002, 1'b0, 1'b0, 1'b0, "R5 subnormal");
    do_cmp(2'b00, 64'h8000_0001, 64'h8000_0002, 1'b0, 1'b0, 1'b0, "R5 negative");

    // R1 R2 R3 R5 R7 R8 R9 R10: pair sweep over each format
    for (int fi = 0; fi < 3; fi++) begin
      logic [1:0] f;
      f = (fi == 0) ? 2'b11 : (fi == 1) ? 2'b00 : 2'b01;
      for (int i = 0; i < 50; i++) begin
        for (int j = 0; j < 50; j++) begin
          do_cmp(f, gen(f, i), gen(f, j), 1'b0, 1'((i + j) % 2),
                 1'(((i * 7 + j) % 3) == 0), "R1/R2/R3/R5/R7/R8/R9/R10 sweep");
        end
      end
      // R6: second operand ignored under compare-with-zero
      for (int i = 0; i < 50; i++) begin
        do_cmp(f, gen(f, i), ~gen(f, i), 1'b1, 1'(i % 2), 1'(i % 3 == 0), "R6 cmpz");
      end
    end

    // R11: undefined code holds flags, no trap even on sNaN
    do_cmp(2'b00, 64'h3F80_0000, 64'h4000_0000, 1'b0, 1'b0, 1'b0, "R2 setup");
    do_cmp(2'b10, 64'h7F80_0001, 64'h7F80_0001, 1'b0, 1'b1, 1'b1, "R11 reserved");
    do_cmp(2'b10, 64'h7F80_0001, 64'h0, 1'b0, 1'b1, 1'b0, "R11 reserved nosticky");
    // R11 on the build without half support, R10 half on the build with it
    valid = 1'b1; fmt = 2'b11; a = 64'h3C00; b = 64'h4000; cmpz = 1'b0; sig = 1'b0; ten = 1'b0;
    held = nzcv1;
    step();
    check("R11 half disabled", {nzcv1, trp1, err1}, {held, 1'b0, 1'b1});
    check("R10 half enabled", {nzcv0, err0}, {4'b1000, 1'b0});
    fmt = 2'b00; a = 64'h4000_0000; b = 64'h3F80_0000;
    step();
    check("R10 single on no-half build", {nzcv1, err1}, {4'b0010, 1'b0});
    exp_nzcv = nzcv0;

    // R12: idle cycles hold flags, no pulses
    valid = 1'b0; a = 64'h7F80_0001; b = 64'h0; ten = 1'b1; fmt = 2'b10;
    held = nzcv0;
    step();
    check("R12 idle", {nzcv0, trp0, err0}, {held, 1'b0, 1'b0});
    step();
    check("R12 idle second", {nzcv0, trp0, err0}, {held, 1'b0, 1'b0});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule